// File: doc/BRIEF.md
# MIDI-Rate Asynchronous Serial Port

This block is a compact asynchronous serial port with a two-address processor interface. It is shaped for MIDI-class links. Address 0 holds the command register on writes and the status register on reads. Address 1 loads the transmit holding register on writes and returns the receive buffer on reads. The character format never changes: one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity.

Software starts the port by writing one of three bit-rate codes. The port comes out of reset with the fourth code, which keeps the whole datapath held in reset. The command register also sets the RTS output, a continuous BREAK level and the transmit interrupt enable, and it holds a receive interrupt enable. The status register reports:

- whether a received byte is waiting;
- whether the holding register can take a byte;
- the level of the clear-to-send pin;
- a framing error;
- a receive overrun;
- the combined interrupt request, which also drives the `irq` pin.

A high level on the clear-to-send pin stops new characters from starting and masks the empty flag.

Top module: `midi_uart`

## Requirements
- R1: After reset, status reads 0x00 while `cts_n` is low. Status bits are: 0 receive-full, 1 transmit-empty, 3 `cts_n` level, 4 framing error, 5 overrun, 7 interrupt. Bits 2 and 6 read 0. After reset `txd` is high, `rts_n` is low and `irq` is low.
- R2: Command bits 1:0 equal to 11 hold the port in reset. This is the value after reset. In this state data writes are ignored, `txd` stays high, nothing is received, and the receive-full, framing and overrun flags are cleared.
- R3: Command bits 1:0 select the rate: 00 is 9600, 01 is 31250 and 10 is 38400 bit/s. One bit lasts 16*round(CLK_HZ/(16*rate)) clock cycles.
- R4: A data write is sent on `txd` as one low start bit, eight data bits least significant first, and one high stop bit. The line idles high.
- R5: A data write clears transmit-empty. The flag returns to 1 when the byte moves into the shifter. While `cts_n` is high, transmit-empty reads 0 and no new character starts.
- R6: Command bits 6:5 set transmit control. `rts_n` is high only for 10. The value 11 drives `txd` low continuously.
- R7: A received character is placed in the data register and sets receive-full. A data read clears receive-full.
- R8: Framing error is set when the stop bit samples low. Each later character updates it.
- R9: A character that arrives while receive-full is set replaces the old byte and sets overrun. A data read clears overrun.
- R10: `irq` equals (bit 7 and (receive-full or overrun)) or (transmit control 01 and transmit-empty). Status bit 7 mirrors `irq`.
- R11: The receiver samples 16 times per bit. A low pulse shorter than half a bit at the start is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 0 selects command/status, 1 selects data |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; a read at address 1 consumes the receive byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, active high |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Embedded properties check four rules on every cycle:

- The transmit line changes only on oversample ticks.
- The holding register drains only while clear-to-send is active, or under the halt code.
- Receive-full falls only after a data read or a halt.
- Overrun rises only over an unread byte.

Other behaviours can only be shown by the bench's scenarios. These are the exact bit period for each rate code, the bit order on the line, decoding of all sampled byte values in loopback, framing-error and glitch handling, the interrupt combinations, and the clearing effect of the halt code.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;

  typedef enum logic [1:0] {
    RATE_9600  = 2'b00,
    RATE_31K25 = 2'b01,
    RATE_38K4  = 2'b10,
    RATE_HALT  = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    TXC_QUIET   = 2'b00,
    TXC_IRQ     = 2'b01,
    TXC_RTS_OFF = 2'b10,
    TXC_BREAK   = 2'b11
  } txctl_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  localparam int OVERSAMPLE = 16;

  // clock cycles per oversample tick, rounded to nearest, never below 1
  function automatic int tick_div(input int clk_hz, input int baud);
    int d;
    d = (clk_hz + (OVERSAMPLE * baud) / 2) / (OVERSAMPLE * baud);
    if (d < 1) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/midi_uart_baud.sv
module midi_uart_baud #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/midi_uart_tx.sv
module midi_uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       tick,
  input  logic       pend,
  input  logic [7:0] pend_data,
  input  logic       cts_n,
  output logic       take,
  output logic       line
);

  localparam int FRAME_BITS = 10;
  localparam int SUB_W = $clog2(midi_uart_pkg::OVERSAMPLE);

  logic                  busy;
  logic [SUB_W-1:0]      sub;
  logic [3:0]            bitn;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sub_last;

  assign sub_last = (sub == SUB_W'(midi_uart_pkg::OVERSAMPLE - 1));
  // a new character starts only on a tick, with the line idle and CTS asserted
  assign take = tick & ~busy & pend & ~cts_n & ~srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '1;
      line  <= 1'b1;
    end else if (srst) begin
      busy  <= 1'b0;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '1;
      line  <= 1'b1;
    end else if (take) begin
      busy  <= 1'b1;
      sub   <= '0;
      bitn  <= '0;
      shreg <= {1'b1, pend_data, 1'b0};
      line  <= 1'b0;
    end else if (tick && busy) begin
      if (sub_last) begin
        sub <= '0;
        if (bitn == 4'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
        end else begin
          bitn  <= bitn + 4'd1;
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          line  <= shreg[1];
        end
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(srst)) |-> $stable(line));

endmodule

// File: rtl/midi_uart_rx.sv
module midi_uart_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       tick,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       ferr
);

  import midi_uart_pkg::*;

  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2 - 1;

  rx_state_e        state;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       shreg;
  logic             s1, s2;
  logic             sub_last;

  assign sub_last = (sub == SUB_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      data  <= '0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (srst) begin
        state <= RX_IDLE;
        sub   <= '0;
        bitn  <= '0;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!s2) begin
              state <= RX_START;
              sub   <= '0;
            end
          end
          RX_START: begin
            if (sub == SUB_W'(MID)) begin
              sub  <= '0;
              bitn <= '0;
              state <= s2 ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          RX_DATA: begin
            if (sub_last) begin
              sub   <= '0;
              shreg <= {s2, shreg[7:1]};
              if (bitn == 3'd7) state <= RX_STOP;
              else              bitn  <= bitn + 3'd1;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          RX_STOP: begin
            if (sub_last) begin
              sub   <= '0;
              done  <= 1'b1;
              data  <= shreg;
              ferr  <= ~s2;
              state <= s2 ? RX_IDLE : RX_HOLD;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          RX_HOLD: begin
            if (s2) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R7
  rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/midi_uart.sv
module midi_uart #(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts_n,
  output logic       rts_n
);

  import midi_uart_pkg::*;

  localparam int DIV_SLOW = tick_div(CLK_HZ, 9600);
  localparam int DIV_MIDI = tick_div(CLK_HZ, 31250);
  localparam int DIV_FAST = tick_div(CLK_HZ, 38400);
  localparam int DIV_W    = $clog2(DIV_SLOW + 1);

  rate_e      rate_q;
  txctl_e     tc_q;
  logic       rie_q;
  logic       cmd_wr, data_wr, data_rd, srst;
  logic [DIV_W-1:0] div;
  logic       tick;
  logic       hold_full;
  logic [7:0] hold_data;
  logic       take, tx_line;
  logic       rx_done, rx_ferr;
  logic [7:0] rx_data, rx_buf;
  logic       rbf, fe, ov, tbe;
  logic [7:0] status;
  logic       cmd_unused;

  assign cmd_wr  = wr_en & ~addr;
  assign data_wr = wr_en & addr;
  assign data_rd = rd_en & addr;
  assign srst    = (rate_q == RATE_HALT);
  assign cmd_unused = ^wdata[4:2];

  always_comb begin
    case (rate_q)
      RATE_9600:  div = DIV_W'(DIV_SLOW);
      RATE_31K25: div = DIV_W'(DIV_MIDI);
      RATE_38K4:  div = DIV_W'(DIV_FAST);
      default:    div = DIV_W'(DIV_SLOW);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_HALT;
      tc_q   <= TXC_QUIET;
      rie_q  <= 1'b0;
    end else if (cmd_wr) begin
      rate_q <= rate_e'(wdata[1:0]);
      tc_q   <= txctl_e'(wdata[6:5]);
      rie_q  <= wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (srst) begin
      hold_full <= 1'b0;
    end else if (data_wr) begin
      hold_full <= 1'b1;
      hold_data <= wdata;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbf    <= 1'b0;
      fe     <= 1'b0;
      ov     <= 1'b0;
      rx_buf <= '0;
    end else if (srst) begin
      rbf <= 1'b0;
      fe  <= 1'b0;
      ov  <= 1'b0;
    end else if (rx_done) begin
      rx_buf <= rx_data;
      fe     <= rx_ferr;
      rbf    <= 1'b1;
      ov     <= (rbf | ov) & ~data_rd;
    end else if (data_rd) begin
      rbf <= 1'b0;
      ov  <= 1'b0;
    end
  end

  assign tbe    = ~hold_full & ~cts_n & ~srst;
  assign irq    = (rie_q & (rbf | ov)) | ((tc_q == TXC_IRQ) & tbe);
  assign rts_n  = (tc_q == TXC_RTS_OFF);
  assign txd    = (tc_q == TXC_BREAK) ? 1'b0 : tx_line;
  assign status = {irq, 1'b0, ov, fe, cts_n, 1'b0, tbe, rbf};
  assign rdata  = addr ? rx_buf : status;

  midi_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(~srst), .div(div), .tick(tick)
  );

  midi_uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick),
    .pend(hold_full), .pend_data(hold_data), .cts_n(cts_n),
    .take(take), .line(tx_line)
  );

  midi_uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick), .rxd(rxd),
    .done(rx_done), .data(rx_data), .ferr(rx_ferr)
  );

  // R7
  rbf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rbf) |-> ($past(data_rd) || $past(srst)));

  // R9
  ov_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov) |-> $past(rbf));

  // R5
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_full) |-> (($past(cts_n) == 1'b0) || $past(srst)));

endmodule

// File: tb/midi_uart_tb.sv
module midi_uart_tb;

  localparam int CLK = 2_457_600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       txd;
  logic       cts_n = 1'b0;
  logic       rts_n;
  logic       rxd_drv = 1'b1;
  logic       loop = 1'b0;
  logic       rxd_line;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  assign rxd_line = loop ? txd : rxd_drv;

  always #4 clk = ~clk;

  midi_uart #(.CLK_HZ(CLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rxd(rxd_line), .txd(txd),
    .cts_n(cts_n), .rts_n(rts_n)
  );

  function automatic int bit_period(input int code);
    real baud;
    int d;
    baud = (code == 0) ? 9600.0 : (code == 1) ? 31250.0 : 38400.0;
    d = $rtoi(real'(CLK) / (16.0 * baud) + 0.5);
    if (d < 1) d = 1;
    return 16 * d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_rbf(output bit got);
    logic [7:0] s;
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      bus_read(1'b0, s);
      if (s[0]) got = 1'b1;
    end
  endtask

  task automatic wait_txd_low(output bit got);
    got = 1'b0;
    for (int i = 0; i < 6000 && !got; i++) begin
      @(negedge clk);
      if (!txd) got = 1'b1;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv, input int p);
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = b[i];
      repeat (p) @(negedge clk);
    end
    rxd_drv = stopv;
    repeat (p) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] b, input int p, input string req);
    bit got;
    int bad;
    logic [9:0] frame;
    frame = {1'b1, b, 1'b0};
    bad = 0;
    wait_txd_low(got);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (txd !== frame[i]) bad++;
      if (i < 9) repeat (p) @(negedge clk);
    end
    chk(got && bad == 0, req, bad, 0);
  endtask

  initial begin
    logic [7:0] s, d;
    bit got;
    int cnt;
    int p;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(1'b0, s);
    chk(s == 8'h00, "R1 status", s, 8'h00);
    chk(txd == 1'b1 && rts_n == 1'b0 && irq == 1'b0, "R1 pins",
        {txd, rts_n, irq}, 3'b100);

    // R2 halted port ignores data and the line
    bus_write(1'b1, 8'h5A);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!txd) cnt++;
    end
    chk(cnt == 0, "R2 no tx while halted", cnt, 0);
    send_rx(8'h77, 1'b1, 64);
    bus_read(1'b0, s);
    chk(s == 8'h00, "R2 no rx while halted", s, 8'h00);

    // R3 / R4 each rate code
    for (int c = 0; c < 3; c++) begin
      p = bit_period(c);
      bus_write(1'b0, 8'(c));
      bus_read(1'b0, s);
      chk(s == 8'h02, "R5 empty after enable", s, 8'h02);
      bus_write(1'b1, 8'h00);
      wait_txd_low(got);
      cnt = 1;
      while (!txd && cnt < 20000) begin
        @(negedge clk);
        if (!txd) cnt++;
      end
      chk(got && cnt == 9 * p, "R3 low span of zero byte", cnt, 9 * p);
      bus_write(1'b1, 8'hA5 + 8'(c * 27));
      tx_check(8'hA5 + 8'(c * 27), p, "R4 frame bits");
    end

    p = bit_period(2);
    repeat (2 * p) @(negedge clk);

    // R4 / R7 loopback sweep
    loop = 1'b1;
    for (int v = 0; v < 256; v += 5) begin
      bus_write(1'b1, 8'(v));
      wait_rbf(got);
      bus_read(1'b1, d);
      chk(got && d == 8'(v), "R7 loopback byte", d, v);
    end
    repeat (2 * p) @(negedge clk);
    loop = 1'b0;
    bus_read(1'b0, s);
    chk((s & 8'h31) == 8'h00, "R7 rbf cleared by read", s & 8'h31, 0);

    // R8 framing
    send_rx(8'h3C, 1'b1, p);
    wait_rbf(got);
    bus_read(1'b0, s);
    chk(got && s[4] == 1'b0, "R8 good frame fe", s, 0);
    bus_read(1'b1, d);
    chk(d == 8'h3C, "R7 rx data", d, 8'h3C);
    send_rx(8'hC3, 1'b0, p);
    wait_rbf(got);
    bus_read(1'b0, s);
    chk(got && s[4] == 1'b1, "R8 missing stop sets fe", s, 8'h10);
    bus_read(1'b1, d);
    chk(d == 8'hC3, "R8 data with fe", d, 8'hC3);
    send_rx(8'h5E, 1'b1, p);
    wait_rbf(got);
    bus_read(1'b0, s);
    chk(got && s[4] == 1'b0, "R8 fe cleared by good frame", s[4], 0);
    bus_read(1'b1, d);

    // R9 overrun
    send_rx(8'h11, 1'b1, p);
    send_rx(8'h22, 1'b1, p);
    bus_read(1'b0, s);
    chk((s & 8'h21) == 8'h21, "R9 ov set", s, 8'h21);
    bus_read(1'b1, d);
    chk(d == 8'h22, "R9 newest byte kept", d, 8'h22);
    bus_read(1'b0, s);
    chk((s & 8'h21) == 8'h00, "R9 ov cleared by read", s & 8'h21, 0);

    // R11 short start glitch rejected
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (p / 4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (12 * p) @(negedge clk);
    bus_read(1'b0, s);
    chk(s[0] == 1'b0, "R11 glitch ignored", s[0], 0);

    // R10 interrupt paths
    bus_write(1'b0, 8'h82);
    @(negedge clk);
    chk(irq == 1'b0, "R10 idle irq", irq, 0);
    send_rx(8'h99, 1'b1, p);
    @(negedge clk);
    bus_read(1'b0, s);
    chk(irq == 1'b1 && s[7] == 1'b1, "R10 rx irq", {irq, s[7]}, 2'b11);
    bus_read(1'b1, d);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq after read", irq, 0);
    bus_write(1'b0, 8'h22);
    @(negedge clk);
    chk(irq == 1'b1, "R10 tx irq on empty", irq, 1);
    cts_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R10 tx irq masked by cts", irq, 0);

    // R5 CTS gating
    bus_read(1'b0, s);
    chk((s & 8'h0A) == 8'h08, "R5 cts bit and tbe low", s & 8'h0A, 8'h08);
    bus_write(1'b1, 8'h96);
    cnt = 0;
    for (int i = 0; i < 20 * p; i++) begin
      @(negedge clk);
      if (!txd) cnt++;
    end
    chk(cnt == 0, "R5 no start while cts high", cnt, 0);
    cts_n = 1'b0;
    tx_check(8'h96, p, "R5 sent after cts");
    bus_read(1'b0, s);
    chk(s[1] == 1'b1, "R5 tbe after load", s[1], 1);
    repeat (2 * p) @(negedge clk);

    // R6 transmit control
    bus_write(1'b0, 8'h42);
    @(negedge clk);
    chk(rts_n == 1'b1, "R6 rts high", rts_n, 1);
    bus_write(1'b0, 8'h62);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd) cnt++;
    end
    chk(cnt == 0 && rts_n == 1'b0, "R6 break level", cnt, 0);
    bus_write(1'b0, 8'h02);
    @(negedge clk);
    chk(txd == 1'b1 && rts_n == 1'b0, "R6 break released", {txd, rts_n}, 2'b10);

    // R2 halt code clears receive flags
    send_rx(8'h44, 1'b0, p);
    send_rx(8'h55, 1'b1, p);
    bus_read(1'b0, s);
    chk((s & 8'h21) == 8'h21, "R2 flags set before halt", s, 8'h21);
    bus_write(1'b0, 8'h03);
    bus_read(1'b0, s);
    chk(s == 8'h00, "R2 halt clears status", s, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
    end
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule